// File: doc/BRIEF.md
# Paged Receive Ring Writer

This block places incoming frames into a circular region of local packet memory that is carved into 256-byte pages. Host configuration fixes the first page of the ring, the end page (one past the last page in the ring) and a hold page that marks where unread data still sits. The block keeps a current-page pointer that names the page where the next frame will begin. The host can load this pointer while the block is idle and can always read it.

A frame arrives as a start strobe, a run of data bytes with a valid strobe, and an end strobe that carries the frame's status byte. Payload bytes are written from offset 4 of the starting page onward. They spill into following pages and wrap from the last ring page back to the first. Once the end strobe arrives, the block writes a 4-byte descriptor into offsets 0 to 3 of the starting page: the status byte, the page where the next frame will start, and the stored length (payload plus 4), low byte first. It then moves the current-page pointer. A frame that would have to enter the hold page is abandoned, and a frame received in monitor mode is never written. Both cases leave the pointer where it was and report a missed frame. Framing, CRC and address filtering happen upstream; the status byte arrives as an input.

Top module: `rx_page_ring`

## Requirements
- R1: After reset, `curPage` and `rxStat` are 0, and `memWe`, `storedPulse`, `droppedPulse` and `ovwPulse` are low.
- R2: A `curWrEn` pulse while no frame is in progress loads `curWrData` into `curPage`; the new value is visible from the next cycle.
- R3: Payload byte i of a frame starting at page P is written to address {page, offset}, where the page is P and the offset is 4+i while 4+i < 256. After offset 255 the write continues at offset 0 of the following page. Each accepted byte gives one `memWe` cycle, one clock after the byte is sampled.
- R4: The page after `cfgEndPage`-1 is `cfgFirstPage`; every write lands in a page p with `cfgFirstPage` <= p < `cfgEndPage`.
- R5: After the last payload byte, four descriptor writes go to offsets 0,1,2,3 of the starting page, in this order: the status byte sampled with `frmEnd`, the next-frame page, the low count byte and the high count byte. The count is the payload length + 4. `storedPulse` is high in the same cycle as the offset-3 write.
- R6: With `storedPulse`, `curPage` becomes the page after the last page that holds payload, and `rxStat` equals the frame's status byte. `curPage` changes at no other time except through R2.
- R7: If the frame's starting page, or any further page it needs, equals `cfgHoldPage`, `ovwPulse` pulses for one cycle and no further write of that frame occurs. No descriptor is written and `curPage` is unchanged. At `frmEnd`, `droppedPulse` pulses and `rxStat` is the status byte with bit 4 (missed) set.
- R8: A frame whose start sees `monitorMode` high produces no memory write and no `ovwPulse`. It ends with `droppedPulse`, with `rxStat` bit 4 set and with `curPage` unchanged.
- R9: A frame whose payload ends exactly at offset 255 is stored even when the following page is the hold page; `curPage` then becomes that following page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgFirstPage | input | 8 | First page of the ring |
| cfgEndPage | input | 8 | One past the last ring page |
| cfgHoldPage | input | 8 | Page the writer must not enter |
| monitorMode | input | 1 | Check-only mode, sampled at frame start |
| curWrEn | input | 1 | Host load of the current page |
| curWrData | input | 8 | Value for the host load |
| curPage | output | 8 | Page where the next frame begins |
| frmStart | input | 1 | Frame start strobe |
| frmValid | input | 1 | Payload byte valid |
| frmData | input | 8 | Payload byte |
| frmEnd | input | 1 | Frame end strobe |
| frmStatus | input | 8 | Receive status, sampled with frmEnd |
| memWe | output | 1 | Packet memory write enable |
| memAddr | output | 16 | Packet memory byte address {page, offset} |
| memWdata | output | 8 | Packet memory write data |
| rxStat | output | 8 | Outcome status of the last frame |
| storedPulse | output | 1 | Frame stored |
| droppedPulse | output | 1 | Frame dropped |
| ovwPulse | output | 1 | Hold page reached |

## Verification
A wrong pointer in the writer shows up on `memAddr` at the first payload byte of the affected frame, or at the first byte after a page crossing. A wrong length or next-page value shows up only in the descriptor bytes, about four cycles after `frmEnd`. A faulty overrun decision shows up one cycle after the byte that would enter the hold page, as an unexpected write or a missing `ovwPulse`. A lost or false pointer update is visible on `curPage` as soon as `storedPulse` has passed, and it also misplaces every later frame.

// File: rtl/rxring_pkg.sv
package rxring_pkg;
  parameter int PAGE_W    = 8;
  parameter int OFF_W     = 8;
  parameter int CNT_W     = 16;
  parameter int HDR_BYTES = 4;
  parameter int MISS_BIT  = 4;
  localparam int ADDR_W   = PAGE_W + OFF_W;

  typedef logic [PAGE_W-1:0] page_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       idle;
    logic       startFrm;
    logic       wrByte;
    logic       endGood;
    logic       hdrWr;
    logic [1:0] hdrSel;
    logic       commit;
    logic       dropEnd;
  } ringStrb_t;

  function automatic page_t stepPage(page_t p, page_t first, page_t stop);
    page_t n;
    n = p + 1'b1;
    return (n == stop) ? first : n;
  endfunction
endpackage

// File: rtl/rxring_ctl.sv
module rxring_ctl
  import rxring_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      frmStart,
  input  logic      frmValid,
  input  logic      frmEnd,
  input  logic      monitorMode,
  input  logic      startBlocked,
  input  logic      byteBlocked,
  output ringStrb_t strb,
  output logic      ovwPulse,
  output logic      storedPulse,
  output logic      droppedPulse
);
  typedef enum logic [1:0] {S_IDLE, S_RECV, S_DROP, S_HDR} state_t;

  state_t     state, stateNxt;
  logic [1:0] hdrCnt;
  logic       ovwNow;

  always_comb begin
    strb     = '0;
    stateNxt = state;
    ovwNow   = 1'b0;
    unique case (state)
      S_IDLE: begin
        strb.idle = 1'b1;
        if (frmStart) begin
          strb.startFrm = 1'b1;
          if (monitorMode) begin
            stateNxt = S_DROP;
          end else if (startBlocked) begin
            stateNxt = S_DROP;
            ovwNow   = 1'b1;
          end else begin
            stateNxt = S_RECV;
          end
        end
      end
      S_RECV: begin
        if (frmEnd) begin
          strb.endGood = 1'b1;
          stateNxt     = S_HDR;
        end else if (frmValid) begin
          if (byteBlocked) begin
            ovwNow   = 1'b1;
            stateNxt = S_DROP;
          end else begin
            strb.wrByte = 1'b1;
          end
        end
      end
      S_DROP: begin
        if (frmEnd) begin
          strb.dropEnd = 1'b1;
          stateNxt     = S_IDLE;
        end
      end
      S_HDR: begin
        strb.hdrWr  = 1'b1;
        strb.hdrSel = hdrCnt;
        if (hdrCnt == 2'd3) begin
          strb.commit = 1'b1;
          stateNxt    = S_IDLE;
        end
      end
      default: stateNxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= S_IDLE;
      hdrCnt       <= 2'd0;
      ovwPulse     <= 1'b0;
      storedPulse  <= 1'b0;
      droppedPulse <= 1'b0;
    end else begin
      state        <= stateNxt;
      hdrCnt       <= strb.hdrWr ? hdrCnt + 2'd1 : 2'd0;
      ovwPulse     <= ovwNow;
      storedPulse  <= strb.commit;
      droppedPulse <= strb.dropEnd;
    end
  end
endmodule

// File: rtl/rxring_dp.sv
module rxring_dp
  import rxring_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ringStrb_t         strb,
  input  page_t             cfgFirstPage,
  input  page_t             cfgEndPage,
  input  page_t             cfgHoldPage,
  input  logic              curWrEn,
  input  page_t             curWrData,
  input  logic [7:0]        frmData,
  input  logic [7:0]        frmStatus,
  output page_t             curPage,
  output logic              startBlocked,
  output logic              byteBlocked,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic [7:0]        rxStat
);
  localparam logic [7:0] MISS_MASK = 8'(1) << MISS_BIT;

  page_t             startPage, wrPage, nextPg, wrStep;
  logic [OFF_W-1:0]  wrOff;
  logic [CNT_W-1:0]  lenCnt, storedCnt;
  logic [7:0]        statLatch, hdrByte;

  assign wrStep       = stepPage(wrPage, cfgFirstPage, cfgEndPage);
  assign startBlocked = (curPage == cfgHoldPage);
  // a new page is only entered when a byte needs it
  assign byteBlocked  = (wrOff == '0) && (wrStep == cfgHoldPage);
  assign storedCnt    = lenCnt + CNT_W'(HDR_BYTES);

  always_comb begin
    unique case (strb.hdrSel)
      2'd0:    hdrByte = statLatch;
      2'd1:    hdrByte = nextPg;
      2'd2:    hdrByte = storedCnt[7:0];
      default: hdrByte = storedCnt[15:8];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPage   <= '0;
      startPage <= '0;
      wrPage    <= '0;
      wrOff     <= '0;
      lenCnt    <= '0;
      nextPg    <= '0;
      statLatch <= '0;
      rxStat    <= '0;
      memWe     <= 1'b0;
      memAddr   <= '0;
      memWdata  <= '0;
    end else begin
      memWe <= 1'b0;
      if (strb.idle && curWrEn) curPage <= curWrData;
      if (strb.startFrm) begin
        startPage <= curPage;
        wrPage    <= curPage;
        wrOff     <= OFF_W'(HDR_BYTES);
        lenCnt    <= '0;
      end
      if (strb.wrByte) begin
        memWe    <= 1'b1;
        memWdata <= frmData;
        wrOff    <= wrOff + 1'b1;
        lenCnt   <= lenCnt + 1'b1;
        if (wrOff == '0) begin
          wrPage  <= wrStep;
          memAddr <= {wrStep, wrOff};
        end else begin
          memAddr <= {wrPage, wrOff};
        end
      end
      if (strb.endGood) begin
        statLatch <= frmStatus;
        nextPg    <= wrStep;
      end
      if (strb.hdrWr) begin
        memWe    <= 1'b1;
        memAddr  <= {startPage, OFF_W'(strb.hdrSel)};
        memWdata <= hdrByte;
      end
      if (strb.commit) begin
        curPage <= nextPg;
        rxStat  <= statLatch;
      end
      if (strb.dropEnd) rxStat <= frmStatus | MISS_MASK;
    end
  end
endmodule

// File: rtl/rx_page_ring.sv
module rx_page_ring
  import rxring_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [PAGE_W-1:0] cfgFirstPage,
  input  logic [PAGE_W-1:0] cfgEndPage,
  input  logic [PAGE_W-1:0] cfgHoldPage,
  input  logic              monitorMode,
  input  logic              curWrEn,
  input  logic [PAGE_W-1:0] curWrData,
  output logic [PAGE_W-1:0] curPage,
  input  logic              frmStart,
  input  logic              frmValid,
  input  logic [7:0]        frmData,
  input  logic              frmEnd,
  input  logic [7:0]        frmStatus,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWdata,
  output logic [7:0]        rxStat,
  output logic              storedPulse,
  output logic              droppedPulse,
  output logic              ovwPulse
);
  ringStrb_t strb;
  logic      startBlocked, byteBlocked;

  rxring_ctl u_ctl (
    .clk, .rstN, .frmStart, .frmValid, .frmEnd, .monitorMode,
    .startBlocked, .byteBlocked, .strb,
    .ovwPulse, .storedPulse, .droppedPulse
  );

  rxring_dp u_dp (
    .clk, .rstN, .strb, .cfgFirstPage, .cfgEndPage, .cfgHoldPage,
    .curWrEn, .curWrData, .frmData, .frmStatus, .curPage,
    .startBlocked, .byteBlocked, .memWe, .memAddr, .memWdata, .rxStat
  );
endmodule

// File: rtl/rx_page_ring_chk.sv
module rx_page_ring_chk
  import rxring_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [PAGE_W-1:0] cfgFirstPage,
  input logic [PAGE_W-1:0] cfgEndPage,
  input logic              curWrEn,
  input logic [PAGE_W-1:0] curPage,
  input logic              memWe,
  input logic [ADDR_W-1:0] memAddr,
  input logic [7:0]        rxStat,
  input logic              storedPulse,
  input logic              droppedPulse,
  input logic              ovwPulse
);
  // R6: stored and dropped are exclusive outcomes
  a_r6_one_outcome: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({storedPulse, droppedPulse}));

  a_r5_hdr_last: assert property (@(posedge clk) disable iff (!rstN)
    storedPulse |-> (memWe && memAddr[OFF_W-1:0] == OFF_W'(3)));

  a_r4_in_ring: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (memAddr[ADDR_W-1:OFF_W] >= cfgFirstPage &&
               memAddr[ADDR_W-1:OFF_W] <  cfgEndPage));

  a_r7_ovw_no_write: assert property (@(posedge clk) disable iff (!rstN)
    ovwPulse |-> !memWe);

  a_r7_drop_keeps_page: assert property (@(posedge clk) disable iff (!rstN)
    droppedPulse |-> $stable(curPage));

  a_r8_drop_missed: assert property (@(posedge clk) disable iff (!rstN)
    droppedPulse |-> rxStat[MISS_BIT]);

  a_r6_page_moves: assert property (@(posedge clk) disable iff (!rstN)
    (curPage != $past(curPage)) |-> (storedPulse || $past(curWrEn)));
endmodule

bind rx_page_ring rx_page_ring_chk i_chk (
  .clk(clk), .rstN(rstN), .cfgFirstPage(cfgFirstPage), .cfgEndPage(cfgEndPage),
  .curWrEn(curWrEn), .curPage(curPage), .memWe(memWe), .memAddr(memAddr),
  .rxStat(rxStat), .storedPulse(storedPulse), .droppedPulse(droppedPulse),
  .ovwPulse(ovwPulse)
);

// File: tb/test_rx_page_ring.sv
`timescale 1ns/1ps
module test_rx_page_ring;
  localparam int FIRST = 'h40;
  localparam int STOP  = 'h48;

  logic        clk = 1'b0, rstN = 1'b0;
  logic [7:0]  cfgFirstPage = 8'(FIRST), cfgEndPage = 8'(STOP), cfgHoldPage = 8'h47;
  logic        monitorMode = 1'b0, curWrEn = 1'b0;
  logic [7:0]  curWrData = '0, curPage;
  logic        frmStart = 1'b0, frmValid = 1'b0, frmEnd = 1'b0;
  logic [7:0]  frmData = '0, frmStatus = '0;
  logic        memWe;
  logic [15:0] memAddr;
  logic [7:0]  memWdata, rxStat;
  logic        storedPulse, droppedPulse, ovwPulse;

  always #2 clk = ~clk;

  rx_page_ring i_rx_page_ring (.*);

  int total = 0, bad = 0;
  int nStored = 0, nDropped = 0, nOvw = 0;
  int modelPage = 0;
  bit done = 1'b0;
  logic [24:0] expQ[$];   // {isHdr, addr, data}

  task automatic check(bit ok, string tag, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected writes and counts event pulses
  always @(negedge clk) begin
    if (rstN) begin
      if (storedPulse)  nStored++;
      if (droppedPulse) nDropped++;
      if (ovwPulse)     nOvw++;
      if (memWe) begin
        if (expQ.size() == 0) begin
          check(1'b0, "R3/R7 unexpected write addr", int'(memAddr), 0);
        end else begin
          logic [24:0] it;
          it = expQ.pop_front();
          if (it[24])
            check({memAddr, memWdata} == it[23:0], "R5 descriptor write",
                  int'({memAddr, memWdata}), int'(it[23:0]));
          else
            check({memAddr, memWdata} == it[23:0], "R3 payload write",
                  int'({memAddr, memWdata}), int'(it[23:0]));
        end
      end
    end
  end

  function automatic int nx(int p);
    return (p + 1 == STOP) ? FIRST : p + 1;
  endfunction

  task automatic hostSet(int pg);
    @(posedge clk); #1;
    curWrEn = 1'b1; curWrData = 8'(pg);
    @(posedge clk); #1;
    curWrEn = 1'b0;
    modelPage = pg;
    @(negedge clk);
    check(curPage == 8'(pg), "R2 host load", curPage, pg);
  endtask

  task automatic sendFrame(int n, int status, bit mon, int seed, string tag);
    int p, o, cnt, s0, d0, v0;
    bit ovf;
    p = modelPage; o = 4; ovf = 1'b0;
    s0 = nStored; d0 = nDropped; v0 = nOvw;
    if (!mon && p == int'(cfgHoldPage)) ovf = 1'b1;
    if (!mon && !ovf) begin
      for (int i = 0; i < n; i++) begin
        if (o == 256) begin
          if (nx(p) == int'(cfgHoldPage)) begin ovf = 1'b1; break; end
          p = nx(p); o = 0;
        end
        expQ.push_back({1'b0, 8'(p), 8'(o), 8'(seed + i)});
        o++;
      end
    end
    if (!mon && !ovf) begin
      cnt = n + 4;
      expQ.push_back({1'b1, 8'(modelPage), 8'd0, 8'(status)});
      expQ.push_back({1'b1, 8'(modelPage), 8'd1, 8'(nx(p))});
      expQ.push_back({1'b1, 8'(modelPage), 8'd2, 8'(cnt)});
      expQ.push_back({1'b1, 8'(modelPage), 8'd3, 8'(cnt >> 8)});
    end
    @(posedge clk); #1;
    frmStart = 1'b1; monitorMode = mon;
    @(posedge clk); #1;
    frmStart = 1'b0; monitorMode = 1'b0;
    for (int i = 0; i < n; i++) begin
      frmValid = 1'b1; frmData = 8'(seed + i);
      @(posedge clk); #1;
    end
    frmValid = 1'b0;
    frmEnd = 1'b1; frmStatus = 8'(status);
    @(posedge clk); #1;
    frmEnd = 1'b0;
    repeat (8) @(posedge clk);
    @(negedge clk);
    if (!mon && !ovf) begin
      modelPage = nx(p);
      check(nStored - s0 == 1 && nDropped == d0, {tag, " R6 stored pulse"}, nStored - s0, 1);
      check(rxStat == 8'(status), {tag, " R6 status"}, rxStat, status);
    end else begin
      check(nDropped - d0 == 1 && nStored == s0, {tag, " R7/R8 dropped pulse"}, nDropped - d0, 1);
      check(rxStat == 8'(status | 'h10), {tag, " R7/R8 missed status"}, rxStat, status | 'h10);
    end
    check(nOvw - v0 == int'(!mon && ovf), {tag, " R7/R8 ovw pulse"}, nOvw - v0, int'(!mon && ovf));
    check(curPage == 8'(modelPage), {tag, " R6/R7 current page"}, curPage, modelPage);
    check(expQ.size() == 0, {tag, " R3/R5 writes missing"}, expQ.size(), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk); #1;
    rstN = 1'b1;
    @(negedge clk);
    check(curPage == 8'h00 && rxStat == 8'h00, "R1 reset regs", {curPage, rxStat}, 0);
    check(!memWe && !storedPulse && !droppedPulse && !ovwPulse, "R1 reset outputs",
          {memWe, storedPulse, droppedPulse, ovwPulse}, 0);
    hostSet(FIRST);
    // R3/R5: short frame
    sendFrame(10, 'h21, 1'b0, 'h10, "short");
    // R9: exact page fill with hold on following page
    cfgHoldPage = 8'h42;
    sendFrame(252, 'h01, 1'b0, 'h33, "R9 exact");
    // R7: start page is the hold page
    sendFrame(5, 'h02, 1'b0, 'h55, "R7 start blocked");
    // R3: frame spanning two pages
    cfgHoldPage = 8'h44;
    sendFrame(300, 'h03, 1'b0, 'h77, "R3 span");
    // R4: wrap from last ring page to first
    cfgHoldPage = 8'h43;
    hostSet('h47);
    sendFrame(400, 'h05, 1'b0, 'h99, "R4 wrap");
    // R7: overrun in mid frame
    cfgHoldPage = 8'h42;
    sendFrame(300, 'h07, 1'b0, 'hAB, "R7 mid overrun");
    // R8: monitor mode
    cfgHoldPage = 8'h47;
    sendFrame(20, 'h09, 1'b1, 'hC0, "R8 monitor");
    // normal frame after drops lands where the pointer stayed
    sendFrame(12, 'h0B, 1'b0, 'hE0, "R6 after drops");
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule